// File: doc/BRIEF.md
# GF(2^128) Reflected-Domain Field Multiplier

This block multiplies two elements of GF(2^128) for an authenticated-encryption datapath whose hash runs in the bit-reflected domain. Bit i of every 128-bit vector is the coefficient of x^i. The field is defined by the reversed polynomial x^128 + x^127 + x^126 + x^121 + 1. The block returns the product scaled by x^-128, which is a Montgomery-style product. Because of this scaling, data never needs to be bit-reflected before it enters the hash. If the caller stores its hash key already multiplied by x, each result is a·b·x^-127, which is the form a reflected hash update needs.

Each operand is split into two 64-bit halves. Four 64x64 carry-less products are formed and folded into a 256-bit unreduced value, held as a high half and a low half. The value is then brought back to 128 bits in two constant-driven phases, using three more 64x64 carry-less products. The block has a fixed two-stage pipeline. It accepts a new operand pair on every clock. A valid strobe qualifies each result, and there is no backpressure on the output.

Top module: `gf128_mont_mul`

## Requirements
- R1: The output equals a·b·x^-128 reduced modulo x^128+x^127+x^126+x^121+1, where bit i of each vector is the coefficient of x^i. The output is fully reduced, meaning its degree is at most 127.
- R2: A result whose a or b operand was all zeros is all zeros.
- R3: The constant 128'hC2000000_00000000_00000000_00000001 acts as the multiplicative identity in either operand position, so the result equals the other operand.
- R4: Swapping a and b gives the same result.
- R5: A pair is accepted on a rising edge where in_valid and in_ready are both high. out_valid rises after exactly two rising edges, counting the accepting edge, and is not high after only one.
- R6: Pairs presented on consecutive cycles are all accepted. Their results appear on consecutive cycles in the same order.
- R7: While no result is due, out_valid is low and out_prod keeps its last value. Operand values presented with in_valid low have no effect on either output.
- R8: While the synchronous reset is high, in_ready, out_valid and out_prod are all 0. in_ready is 1 from the first rising edge after reset is released.
- R9: The product distributes over field addition: (a1 XOR a2)·b equals (a1·b) XOR (a2·b).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can accept a pair (high whenever out of reset) |
| in_a | input | 128 | First operand |
| in_b | input | 128 | Second operand |
| out_valid | output | 1 | out_prod holds a new result this cycle |
| out_prod | output | 128 | Reduced product a·b·x^-128 |

## Verification
A fault in the fold of the cross term, in the first reduction phase or in the second-phase shifts corrupts the result of the very pair that exercises it. The wrong value appears two edges after acceptance, and comparison with a bit-serial shift-and-reduce model catches it. Faults that only touch rarely set bits are exposed through the identity constant, the all-ones operands and distributivity. A fault in the valid pipeline shows as a result one cycle early or late, a dropped result in a back-to-back stream, or an output that changes while out_valid is low. Each of these is visible at the ports within a cycle or two.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  localparam int unsigned ELEM_W    = 128;
  localparam int unsigned HALF_W    = ELEM_W / 2;
  localparam int unsigned RED_SHIFT = HALF_W / 2;
  localparam int unsigned WIDE_W    = 2 * ELEM_W;

  // Upper half of x^128 mod P, used to zero the low word in phase one
  localparam logic [HALF_W-1:0] RED_K_HI = 64'hC200_0000_0000_0000;
  // (x^64 + RED_K_HI) >> 32, used by both phase-two products
  localparam logic [HALF_W-1:0] RED_K_LO = 64'h0000_0001_C200_0000;
  // x^128 mod P: identity of the scaled product
  localparam logic [ELEM_W-1:0] MONT_ONE =
    128'hC200_0000_0000_0000_0000_0000_0000_0001;

  typedef logic [ELEM_W-1:0] gf_elem_t;
  typedef logic [HALF_W-1:0] gf_half_t;

  typedef struct packed {
    gf_elem_t hi;
    gf_elem_t lo;
  } gf_wide_t;
endpackage

// File: rtl/gfm_clmul.sv
module gfm_clmul #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] rows [W];

  // one shifted partial row per multiplier bit
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_row
      assign rows[i] = x[i] ? ({{W{1'b0}}, y} << i) : '0;
    end
  endgenerate

  always_comb begin
    p = '0;
    for (int k = 0; k < W; k++) begin
      p = p ^ rows[k];
    end
  end
endmodule

// File: rtl/gfm_fold_stage.sv
module gfm_fold_stage
  import gfm_pkg::*;
#(
  parameter int unsigned EW = ELEM_W,
  parameter int unsigned HW = EW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_fire,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic          s1_valid,
  output logic [EW-1:0] s1_hi,
  output logic [EW-1:0] s1_lo
);
  localparam int unsigned NPP = 4;

  // pp[k]: a half (k/2) times b half (k%2)
  logic [EW-1:0] pp [NPP];

  genvar k;
  generate
    for (k = 0; k < NPP; k++) begin : g_pp
      localparam int unsigned AS = k / 2;
      localparam int unsigned BS = k % 2;
      gfm_clmul #(.W(HW)) u_mul (
        .x (a[AS*HW +: HW]),
        .y (b[BS*HW +: HW]),
        .p (pp[k])
      );
    end
  endgenerate

  logic [EW-1:0] mid;
  logic [EW-1:0] fold_lo;
  logic [EW-1:0] fold_hi;

  always_comb begin
    mid     = pp[1] ^ pp[2];
    fold_lo = pp[0] ^ (mid << HW);
    fold_hi = pp[3] ^ (mid >> HW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_hi    <= '0;
      s1_lo    <= '0;
    end else begin
      s1_valid <= in_fire;
      if (in_fire) begin
        s1_hi <= fold_hi;
        s1_lo <= fold_lo;
      end
    end
  end

  AST_S1_TAKES_PAIR: assert property (@(posedge clk) disable iff (rst)
    in_fire |=> s1_valid); // R6

  AST_S1_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_fire |=> ($stable(s1_hi) && $stable(s1_lo))); // R7
endmodule

// File: rtl/gfm_reduce_stage.sv
module gfm_reduce_stage
  import gfm_pkg::*;
#(
  parameter int unsigned EW = ELEM_W,
  parameter int unsigned HW = EW / 2,
  parameter int unsigned SH = HW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s1_valid,
  input  logic [EW-1:0] s1_hi,
  input  logic [EW-1:0] s1_lo,
  output logic          out_valid,
  output logic [EW-1:0] out_prod
);
  logic [EW-1:0] ph1_prod;
  logic [EW-1:0] lo_m;
  logic [EW-1:0] t_lo;
  logic [EW-1:0] t_hi;
  logic [EW-1:0] result;

  // phase one: clear the low word's contribution modulo x^128
  gfm_clmul #(.W(HW)) u_ph1 (
    .x (RED_K_HI),
    .y (s1_lo[HW-1:0]),
    .p (ph1_prod)
  );

  assign lo_m = s1_lo ^ (ph1_prod << HW);

  // phase two: fold the adjusted low value into the high half
  gfm_clmul #(.W(HW)) u_ph2_lo (
    .x (RED_K_LO),
    .y (lo_m[HW-1:0]),
    .p (t_lo)
  );

  gfm_clmul #(.W(HW)) u_ph2_hi (
    .x (RED_K_LO),
    .y (lo_m[EW-1:HW]),
    .p (t_hi)
  );

  assign result = s1_hi ^ (t_lo >> SH) ^ (t_hi << SH);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_prod <= result;
      end
    end
  end

  AST_OUT_FOLLOWS_S1: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid); // R5

  AST_ZERO_STAGE: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_hi == '0 && s1_lo == '0) |=> (out_prod == '0)); // R2
endmodule

// File: rtl/gf128_mont_mul.sv
module gf128_mont_mul
  import gfm_pkg::*;
#(
  parameter int unsigned EW = ELEM_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [EW-1:0] in_a,
  input  logic [EW-1:0] in_b,
  output logic          out_valid,
  output logic [EW-1:0] out_prod
);
  localparam int unsigned HW = EW / 2;

  logic          in_fire;
  logic          s1_valid;
  logic [EW-1:0] s1_hi;
  logic [EW-1:0] s1_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready <= 1'b0;
    end else begin
      in_ready <= 1'b1;
    end
  end

  assign in_fire = in_valid & in_ready;

  gfm_fold_stage #(.EW(EW), .HW(HW)) u_fold (
    .clk      (clk),
    .rst      (rst),
    .in_fire  (in_fire),
    .a        (in_a),
    .b        (in_b),
    .s1_valid (s1_valid),
    .s1_hi    (s1_hi),
    .s1_lo    (s1_lo)
  );

  gfm_reduce_stage #(.EW(EW), .HW(HW), .SH(HW / 2)) u_red (
    .clk       (clk),
    .rst       (rst),
    .s1_valid  (s1_valid),
    .s1_hi     (s1_hi),
    .s1_lo     (s1_lo),
    .out_valid (out_valid),
    .out_prod  (out_prod)
  );

  AST_READY_OUT_OF_RST: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> in_ready); // R8

  AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_fire, 2)); // R5

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(in_a, 2) == '0 || $past(in_b, 2) == '0))
      |-> (out_prod == '0)); // R2

  AST_IDENTITY_B: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_b, 2) == MONT_ONE)
      |-> (out_prod == $past(in_a, 2))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_prod)); // R7
endmodule

// File: tb/gf128_mont_mul_tb.sv
`timescale 1ns/1ps
module gf128_mont_mul_tb;
  localparam int STREAM_N = 12;
  localparam int WDOG_CYC = 200000;
  localparam logic [127:0] ONE_C = 128'hC200_0000_0000_0000_0000_0000_0000_0001;
  localparam logic [256:0] POLY_R =
    (257'b1 << 128) | (257'b1 << 127) | (257'b1 << 126) | (257'b1 << 121) | 257'b1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_a = '0;
  logic [127:0] in_b = '0;
  wire          in_ready;
  wire          out_valid;
  wire  [127:0] out_prod;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;

  gf128_mont_mul u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_prod  (out_prod)
  );

  // bit-serial model: full product, then 128 divide-by-x steps
  function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
    logic [256:0] acc;
    acc = '0;
    for (int i = 0; i < 128; i++)
      if (a[i]) acc = acc ^ ({129'b0, b} << i);
    for (int i = 0; i < 128; i++) begin
      if (acc[0]) acc = acc ^ POLY_R;
      acc = acc >> 1;
    end
    return acc[127:0];
  endfunction

  function automatic logic [63:0] xs(input logic [63:0] v);
    logic [63:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  task automatic rnd128(output logic [127:0] v);
    rs = xs(rs);
    v[127:64] = rs;
    rs = xs(rs);
    v[63:0] = rs;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one pair from an idle pipeline; checks timing (R5) and returns the result
  task automatic mul_once(input logic [127:0] a, input logic [127:0] b,
                          output logic [127:0] res);
    @(negedge clk);
    in_a = a; in_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R5", "valid after one edge", {127'b0, out_valid}, 128'd0);
    @(negedge clk);
    check(out_valid == 1'b1, "R5", "valid after two edges", {127'b0, out_valid}, 128'd1);
    res = out_prod;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R8", "in_ready in reset", {127'b0, in_ready}, 128'd0);
    check(out_valid == 1'b0, "R8", "out_valid in reset", {127'b0, out_valid}, 128'd0);
    check(out_prod == '0, "R8", "out_prod in reset", out_prod, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R8", "in_ready after reset", {127'b0, in_ready}, 128'd1);
    check(out_valid == 1'b0, "R8", "out_valid after reset", {127'b0, out_valid}, 128'd0);
  endtask

  task automatic t_zero();
    logic [127:0] x, r;
    rnd128(x);
    mul_once('0, x, r);
    check(r == '0, "R2", "zero times random", r, 128'd0);
    mul_once(x, '0, r);
    check(r == '0, "R2", "random times zero", r, 128'd0);
    mul_once('0, '0, r);
    check(r == '0, "R2", "zero times zero", r, 128'd0);
  endtask

  task automatic t_identity();
    logic [127:0] x, r;
    rnd128(x);
    mul_once(x, ONE_C, r);
    check(r == x, "R3", "identity in b", r, x);
    mul_once(ONE_C, x, r);
    check(r == x, "R3", "identity in a", r, x);
    mul_once('1, ONE_C, r);
    check(r == '1, "R3", "identity on all-ones", r, '1);
  endtask

  task automatic t_model();
    logic [127:0] x, y, r, e;
    mul_once('1, '1, r);
    e = ref_mul('1, '1);
    check(r == e, "R1", "all-ones squared", r, e);
    mul_once(128'd1, 128'd1, r);
    e = ref_mul(128'd1, 128'd1);
    check(r == e, "R1", "unit squared", r, e);
    mul_once(128'd1 << 127, 128'd1 << 64, r);
    e = ref_mul(128'd1 << 127, 128'd1 << 64);
    check(r == e, "R1", "high single bits", r, e);
    for (int n = 0; n < 6; n++) begin
      rnd128(x); rnd128(y);
      mul_once(x, y, r);
      e = ref_mul(x, y);
      check(r == e, "R1", "random pair", r, e);
    end
  endtask

  task automatic t_commute();
    logic [127:0] x, y, r1, r2;
    for (int n = 0; n < 3; n++) begin
      rnd128(x); rnd128(y);
      mul_once(x, y, r1);
      mul_once(y, x, r2);
      check(r1 == r2, "R4", "swapped operands", r2, r1);
    end
  endtask

  task automatic t_linear();
    logic [127:0] x1, x2, y, r1, r2, r3;
    rnd128(x1); rnd128(x2); rnd128(y);
    mul_once(x1, y, r1);
    mul_once(x2, y, r2);
    mul_once(x1 ^ x2, y, r3);
    check(r3 == (r1 ^ r2), "R9", "distributive sum", r3, r1 ^ r2);
  endtask

  task automatic t_idle();
    logic [127:0] x, y, r, junk;
    rnd128(x); rnd128(y);
    mul_once(x, y, r);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7", "no valid while idle", {127'b0, out_valid}, 128'd0);
      check(out_prod == r, "R7", "result held while idle", out_prod, r);
      rnd128(junk); in_a = junk;
      rnd128(junk); in_b = junk;
    end
  endtask

  task automatic t_stream();
    logic [127:0] sa [STREAM_N];
    logic [127:0] sb [STREAM_N];
    logic [127:0] e;
    for (int n = 0; n < STREAM_N; n++) begin
      rnd128(sa[n]); rnd128(sb[n]);
    end
    sa[3] = '0;
    sb[7] = ONE_C;
    for (int c = 0; c < STREAM_N + 2; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        e = ref_mul(sa[c-2], sb[c-2]);
        check(out_valid == 1'b1, "R6", "stream result valid", {127'b0, out_valid}, 128'd1);
        check(out_prod == e, "R6", "stream result in order", out_prod, e);
      end else begin
        check(out_valid == 1'b0, "R6", "stream not early", {127'b0, out_valid}, 128'd0);
      end
      if (c < STREAM_N) begin
        in_a = sa[c]; in_b = sb[c]; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R6", "stream ends", {127'b0, out_valid}, 128'd0);
  endtask

  initial begin
    t_reset();
    t_zero();
    t_identity();
    t_model();
    t_commute();
    t_linear();
    t_idle();
    t_stream();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule